// File: doc/BRIEF.md
# Frame-Paced Conversion Sequencer

This block decides when a bank of data converters samples. It watches two slow external signals, a conversion clock and a frame trigger. It turns falling edges of the conversion clock into single-cycle conversion pulses in the fast system clock domain. Both signals are brought into that domain through a configurable synchronizer chain, which has two stages by default. The block keeps a running tally of the pulses it has issued. It also drives a busy flag, a sticky frame-error flag and a completion interrupt flag.

The operating style is chosen when the unit is enabled. In continuous style, the unit waits until it has seen a rising conversion clock edge. From then on, every falling edge yields one pulse. In frame style, each frame trigger clears the tally and loads the programmed conversion count. The following falling edges then yield pulses until that count is reached, and further falling edges are ignored until the next trigger. A trigger that arrives while a frame is still short of its count is a frame error. The unit then freezes and stays frozen until it is disabled or given a one-cycle restart.

Top module: `conv_sequencer`

## Requirements
- R1: After synchronous reset, conv_pulse, busy, frame_err and done_irq are 0 and conv_count is 0.
- R2: In continuous style (frame_mode=0 when enable rises), no pulse is issued before a rising conversion clock edge has been seen since the unit was armed. After that, each falling edge issues exactly one pulse and increments conv_count.
- R3: In frame style (frame_mode=1), a frame trigger rising edge clears conv_count and loads num_conv. Each later falling conversion clock edge issues one pulse until conv_count equals the loaded value. Extra falling edges issue nothing and leave conv_count unchanged.
- R4: busy is 1 while conversions are pending in a frame, and while a continuous-style unit is armed and running. It falls to 0 once the frame's programmed count is done.
- R5: On completion of a frame, done_irq is set only if irq_en is 1. irq_ack clears it.
- R6: A frame trigger rising edge that arrives while a frame is busy sets frame_err. After that, no pulses are issued, conv_count is frozen, and further triggers do not clear it.
- R7: Driving enable low, or pulsing unit_reset, clears frame_err, done_irq, busy and conv_count, and re-arms the unit (a rising conversion clock edge is needed again in continuous style).
- R8: A frame trigger with num_conv=0 issues no pulses, leaves busy at 0 and sets no done_irq.
- R9: conv_pulse is high for one system clock per accepted falling edge, never two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Unit enable; low holds the unit in its cleared state |
| unit_reset | input | 1 | One-cycle restart of the unit while enabled |
| frame_mode | input | 1 | 0 continuous style, 1 frame style; sampled when the unit arms |
| num_conv | input | 16 | Conversions per frame, loaded at each accepted trigger |
| irq_en | input | 1 | Permits done_irq to be set |
| irq_ack | input | 1 | Clears done_irq |
| conv_clk | input | 1 | Asynchronous conversion clock |
| frame_trig | input | 1 | Asynchronous frame trigger |
| conv_pulse | output | 1 | One-cycle conversion strobe |
| busy | output | 1 | Conversions pending or running |
| conv_count | output | 16 | Conversions since the last trigger or re-arm |
| frame_err | output | 1 | Sticky frame error |
| done_irq | output | 1 | Frame completion interrupt flag |

## Verification
The bench builds the block with the default 16-bit count and two synchronizer stages. It holds each level of the slow inputs for four system clocks. This keeps every falling edge clear of the three-cycle latency from pin to pulse, so pulse totals can be counted exactly. The small frame lengths of zero to six reach the empty frame, the single-conversion frame, a frame cut short by a trigger, and a frame that is given more edges than it needs.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_RUN,
        ST_WAIT,
        ST_FRAME,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic state_busy(seq_state_e s);
        return (s == ST_RUN) || (s == ST_FRAME);
    endfunction

endpackage

// File: rtl/seq_edge_sync.sv
module seq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    output seq_pkg::edge_t  ev
);
    logic [STAGES-1:0] chain;
    logic              last;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign ev.rise = chain[STAGES-1] & ~last;
    assign ev.fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/seq_conv_counter.sv
module seq_conv_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

    assign last = ((count + 1'b1) == limit);
endmodule

// File: rtl/seq_frame_ctrl.sv
module seq_frame_ctrl
    import seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         unit_reset,
    input  logic         frame_mode,
    input  logic [W-1:0] num_conv,
    input  logic         irq_en,
    input  logic         irq_ack,
    input  edge_t        cc_ev,
    input  edge_t        ft_ev,
    input  logic [W-1:0] count,
    input  logic         last,
    output logic [W-1:0] limit,
    output logic         cnt_clr,
    output logic         cnt_inc,
    output logic         conv_pulse,
    output logic         busy,
    output logic         frame_err,
    output logic         done_irq
);
    seq_state_e   state, nxt;
    logic         mode_q;
    logic [W-1:0] num_q;
    logic         pulse_d, err_set, done_set, load_num, restart;

    assign restart = !enable || unit_reset;

    always_comb begin
        nxt      = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        pulse_d  = 1'b0;
        err_set  = 1'b0;
        done_set = 1'b0;
        load_num = 1'b0;
        if (restart) begin
            nxt     = ST_OFF;
            cnt_clr = 1'b1;
        end else begin
            case (state)
                ST_OFF: begin
                    cnt_clr = 1'b1;
                    nxt     = frame_mode ? ST_WAIT : ST_ARM;
                end
                ST_ARM: if (cc_ev.rise) nxt = ST_RUN;
                ST_RUN: if (cc_ev.fall) begin
                    pulse_d = 1'b1;
                    cnt_inc = 1'b1;
                end
                ST_WAIT: if (ft_ev.rise) begin
                    cnt_clr  = 1'b1;
                    load_num = 1'b1;
                    if (num_conv != '0) nxt = ST_FRAME;
                end
                ST_FRAME: begin
                    if (ft_ev.rise) begin
                        err_set = 1'b1;
                        nxt     = ST_HALT;
                    end else if (cc_ev.fall) begin
                        pulse_d = 1'b1;
                        cnt_inc = 1'b1;
                        if (last) begin
                            done_set = 1'b1;
                            nxt      = ST_WAIT;
                        end
                    end
                end
                ST_HALT: nxt = ST_HALT;
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OFF;
            mode_q     <= 1'b0;
            num_q      <= '0;
            conv_pulse <= 1'b0;
            frame_err  <= 1'b0;
            done_irq   <= 1'b0;
        end else begin
            state      <= nxt;
            conv_pulse <= pulse_d;
            if (state == ST_OFF) mode_q <= frame_mode;
            if (load_num)        num_q  <= num_conv;
            if (restart)         frame_err <= 1'b0;
            else if (err_set)    frame_err <= 1'b1;
            if (restart)                 done_irq <= 1'b0;
            else if (done_set && irq_en) done_irq <= 1'b1;
            else if (irq_ack)            done_irq <= 1'b0;
        end
    end

    assign busy  = state_busy(state);
    assign limit = num_q;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_pulse |=> !conv_pulse);

    a_r6_no_pulse_on_error: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !conv_pulse);

    a_r6_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> (state != ST_HALT || $stable(count)));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME) |-> (count < num_q));

    a_r8_zero_frame_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && enable && !unit_reset && ft_ev.rise && num_conv == '0)
        |=> !busy);

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!frame_err && !done_irq && count == '0));

    a_r2_mode_sampled: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> !mode_q);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             unit_reset,
    input  logic             frame_mode,
    input  logic [CNT_W-1:0] num_conv,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             conv_clk,
    input  logic             frame_trig,
    output logic             conv_pulse,
    output logic             busy,
    output logic [CNT_W-1:0] conv_count,
    output logic             frame_err,
    output logic             done_irq
);
    import seq_pkg::*;

    edge_t            cc_ev, ft_ev;
    logic             cnt_clr, cnt_inc, cnt_last;
    logic [CNT_W-1:0] limit;

    seq_edge_sync #(.STAGES(SYNC_STAGES)) u_cc_sync (
        .clk(clk), .rst(rst), .din(conv_clk), .ev(cc_ev)
    );

    seq_edge_sync #(.STAGES(SYNC_STAGES)) u_ft_sync (
        .clk(clk), .rst(rst), .din(frame_trig), .ev(ft_ev)
    );

    seq_conv_counter #(.W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .limit(limit), .count(conv_count), .last(cnt_last)
    );

    seq_frame_ctrl #(.W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .enable(enable), .unit_reset(unit_reset),
        .frame_mode(frame_mode), .num_conv(num_conv), .irq_en(irq_en),
        .irq_ack(irq_ack), .cc_ev(cc_ev), .ft_ev(ft_ev), .count(conv_count),
        .last(cnt_last), .limit(limit), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .conv_pulse(conv_pulse), .busy(busy), .frame_err(frame_err),
        .done_irq(done_irq)
    );
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    typedef struct packed {
        logic        mode;
        logic [15:0] num;
        logic [7:0]  ncyc;
        logic [7:0]  exp_pulses;
        logic [15:0] exp_count;
        logic        exp_busy;
        logic        exp_done;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 16'd3, 8'd5, 8'd3, 16'd3, 1'b0, 1'b1},
        '{1'b1, 16'd1, 8'd2, 8'd1, 16'd1, 1'b0, 1'b1},
        '{1'b1, 16'd4, 8'd4, 8'd4, 16'd4, 1'b0, 1'b1},
        '{1'b1, 16'd0, 8'd3, 8'd0, 16'd0, 1'b0, 1'b0},
        '{1'b0, 16'd5, 8'd4, 8'd4, 16'd4, 1'b1, 1'b0},
        '{1'b1, 16'd6, 8'd3, 8'd3, 16'd3, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, unit_reset = 1'b0, frame_mode = 1'b0;
    logic [15:0] num_conv = '0;
    logic        irq_en = 1'b1, irq_ack = 1'b0;
    logic        conv_clk = 1'b0, frame_trig = 1'b0;
    logic        conv_pulse, busy, frame_err, done_irq;
    logic [15:0] conv_count;

    int checks = 0, fails = 0, pulses = 0, doubles = 0;
    logic prev_pulse = 1'b0;
    bit   finished = 0;

    conv_sequencer dut (
        .clk(clk), .rst(rst), .enable(enable), .unit_reset(unit_reset),
        .frame_mode(frame_mode), .num_conv(num_conv), .irq_en(irq_en),
        .irq_ack(irq_ack), .conv_clk(conv_clk), .frame_trig(frame_trig),
        .conv_pulse(conv_pulse), .busy(busy), .conv_count(conv_count),
        .frame_err(frame_err), .done_irq(done_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (conv_pulse) pulses++;
        if (conv_pulse && prev_pulse) doubles++;
        prev_pulse = conv_pulse;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cc_cycle(input int n);
        for (int i = 0; i < n; i++) begin
            conv_clk = 1'b1; wait_clk(HOLD);
            conv_clk = 1'b0; wait_clk(HOLD);
        end
    endtask

    task automatic trigger();
        frame_trig = 1'b1; wait_clk(HOLD);
        frame_trig = 1'b0; wait_clk(HOLD);
    endtask

    task automatic arm(input logic mode, input logic [15:0] n);
        enable = 1'b0; wait_clk(3);
        frame_mode = mode; num_conv = n;
        enable = 1'b1; wait_clk(4);
        pulses = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(3);
        // R1 reset state
        check("R1 pulse", conv_pulse, 0);
        check("R1 busy", busy, 0);
        check("R1 count", conv_count, 0);
        check("R1 err", frame_err, 0);
        check("R1 done", done_irq, 0);
        rst = 1'b0;
        wait_clk(2);

        // Table walk: R2 R3 R4 R5 R8
        for (int v = 0; v < 6; v++) begin
            irq_en = 1'b1;
            arm(VECS[v].mode, VECS[v].num);
            if (VECS[v].mode) trigger();
            cc_cycle(VECS[v].ncyc);
            wait_clk(6);
            check($sformatf("R3/R2 pulses vec%0d", v), pulses, VECS[v].exp_pulses);
            check($sformatf("R3/R2 count vec%0d", v), conv_count, VECS[v].exp_count);
            check($sformatf("R4/R8 busy vec%0d", v), busy, VECS[v].exp_busy);
            check($sformatf("R5/R8 done vec%0d", v), done_irq, VECS[v].exp_done);
        end

        // R6 frame error and freeze
        arm(1'b1, 16'd4);
        trigger();
        cc_cycle(2);
        wait_clk(4);
        check("R6 count before error", conv_count, 2);
        check("R4 busy mid frame", busy, 1);
        trigger();
        check("R6 err set", frame_err, 1);
        cc_cycle(2);
        wait_clk(4);
        check("R6 no pulses after error", pulses, 2);
        trigger();
        check("R6 count frozen", conv_count, 2);
        check("R6 err sticky", frame_err, 1);
        // R7 disable clears
        enable = 1'b0; wait_clk(3);
        check("R7 err cleared", frame_err, 0);
        check("R7 count cleared", conv_count, 0);

        // R3 R5 retrigger after complete frame, irq_ack
        arm(1'b1, 16'd2);
        trigger();
        cc_cycle(3);
        wait_clk(4);
        check("R3 count at end", conv_count, 2);
        check("R5 done set", done_irq, 1);
        irq_ack = 1'b1; wait_clk(1); irq_ack = 1'b0; wait_clk(1);
        check("R5 ack clears", done_irq, 0);
        trigger();
        wait_clk(2);
        check("R3 retrigger clears count", conv_count, 0);
        check("R6 no error on clean retrigger", frame_err, 0);
        check("R4 busy after retrigger", busy, 1);

        // R5 gating
        irq_en = 1'b0;
        arm(1'b1, 16'd1);
        trigger();
        cc_cycle(1);
        wait_clk(4);
        check("R5 pulse with gate off", pulses, 1);
        check("R5 done gated", done_irq, 0);
        irq_en = 1'b1;

        // R2 arming with conv_clk already high
        enable = 1'b0;
        conv_clk = 1'b1; wait_clk(8);
        frame_mode = 1'b0; enable = 1'b1; wait_clk(4);
        pulses = 0;
        conv_clk = 1'b0; wait_clk(6);
        check("R2 no pulse before rise", pulses, 0);
        check("R2 not busy while arming", busy, 0);
        cc_cycle(2);
        wait_clk(4);
        check("R2 pulses after rise", pulses, 2);
        check("R2 count", conv_count, 2);
        // R7 unit_reset
        unit_reset = 1'b1; wait_clk(1); unit_reset = 1'b0; wait_clk(2);
        check("R7 restart count", conv_count, 0);
        check("R7 restart busy", busy, 0);
        cc_cycle(1);
        wait_clk(4);
        check("R7 rearmed count", conv_count, 1);

        // R9 pulse width
        check("R9 back-to-back pulses", doubles, 0);

        finish_run();
    end
endmodule